// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block turns one scalar-encoded operation into a stream of per-element micro-operations. A command names a destination and two source registers, says which of them are vectors, and gives a vector length, a predicate mask and a zeroing choice. The sequencer then works out which elements must go out and in what order. It hands them downstream in groups of up to `LANES` element issues per cycle. Each issue carries the element number, an enable bit, a zero-write bit and the three element register numbers.

With zeroing off, elements whose predicate bit is clear are dropped from the stream, so only real work takes ALU lanes. For example, 8 elements with 6 active need 6 groups on a single lane, but only 2 groups (4 then 2) on four lanes. With zeroing on, every element inside the vector length is issued, and those whose predicate bit is clear are flagged so that zero is written in place of a result. The register file, the arithmetic and the register-mapping tables all sit outside this block.

Top module: `elemIssueSeq`

## Requirements
- R1: A command on `start` is taken only while `busy` is low. A `start` raised while `busy` is high is ignored and leaves the stream in progress unchanged.
- R2: Only elements with number below the effective vector length take part. A `cmdVl` above `XLEN` acts as `XLEN`, and `cmdVl` = 0 yields no issue at all.
- R3: With `cmdZero` = 0, element i is issued only if bit i of `cmdMask` is 1. Every issued element then has `laneEnable` = 1 and `laneZero` = 0, and skipped elements take no lane.
- R4: Each group holds the lowest-numbered elements still pending, at most `LANES` of them. Lane 0 holds the lowest element, and element numbers rise with the lane number. Filled lanes are contiguous from lane 0, and unfilled lanes have `laneValid` = 0.
- R5: For an element e, a register marked vector is issued as (base + e) modulo 2^`REG_W`. A register not marked vector is issued as its base for every element.
- R6: With `cmdZero` = 1, every element below the effective length is issued. Its `laneEnable` equals its mask bit and its `laneZero` is the inverse of that bit.
- R7: When none of the three registers is marked vector, the effective vector length is 1 (0 if `cmdVl` = 0). Only element 0 is considered, and it is still subject to the predicate and zeroing rules.
- R8: While `outValid` = 1 and `outReady` = 0, the group on the outputs stays unchanged and `outValid` stays high.
- R9: `done` is high for exactly one cycle: the cycle after the last group is accepted, or the cycle after a command with nothing to issue is taken. `outValid` never rises for such an empty command.
- R10: A command with n issued elements takes exactly ceil(n / `LANES`) accepted groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| cmdRd | input | REG_W | Destination base register |
| cmdRs1 | input | REG_W | First source base register |
| cmdRs2 | input | REG_W | Second source base register |
| cmdVecRd | input | 1 | Destination is a vector |
| cmdVecRs1 | input | 1 | First source is a vector |
| cmdVecRs2 | input | 1 | Second source is a vector |
| cmdVl | input | VL_W | Requested vector length (0..2^VL_W-1) |
| cmdMask | input | XLEN | Predicate mask, bit i for element i |
| cmdZero | input | 1 | Zeroing mode for inactive elements |
| busy | output | 1 | A command is being issued |
| outValid | output | 1 | An issue group is presented |
| outReady | input | 1 | Downstream accepts the group |
| laneValid | output | LANES | Per-lane issue valid |
| laneEnable | output | LANES | Per-lane predicate enable |
| laneZero | output | LANES | Per-lane write-zero flag |
| laneElem | output | LANES*ELEM_W | Per-lane element number |
| laneRd | output | LANES*REG_W | Per-lane destination register |
| laneRs1 | output | LANES*REG_W | Per-lane first source register |
| laneRs2 | output | LANES*REG_W | Per-lane second source register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `outReady` is a free input sampled only while `outValid` is high, and that command fields only matter in the cycle `start` is taken. They also assume reset is applied before the first command. The stimulus drives `start` only at idle, except for deliberate extra pulses during a busy run, and it toggles `outReady` randomly while a group is pending. Command fields are drawn at random over the full range of `cmdVl`, including lengths above `XLEN`, along with random masks, vector flags and zeroing. These are mixed with directed cases for zero length, empty masks, the 6-of-8 pattern and fully scalar commands.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobeT;

  // status from datapath to control
  typedef struct packed {
    logic loadEmpty;
    logic lastGroup;
  } seqStatusT;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      outReady,
  input  seqStatusT status,
  output seqStrobeT strobe,
  output logic      busy,
  output logic      outValid,
  output logic      done
);

  seqStateT stateQ;
  seqStateT stateD;
  logic     accept;
  logic     fire;
  logic     doneQ;

  assign accept = start && (stateQ == ST_IDLE);
  assign fire   = (stateQ == ST_RUN) && outReady;

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.advance = fire;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept && !status.loadEmpty) stateD = ST_RUN;
      ST_RUN:  if (fire && status.lastGroup)    stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (accept && status.loadEmpty) || (fire && status.lastGroup);
    end
  end

  assign busy     = (stateQ == ST_RUN);
  assign outValid = (stateQ == ST_RUN);
  assign done     = doneQ;

  // R9: the completion pulse always falls in an idle cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: a start seen while busy never drops the command in flight
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !outReady) |=> busy);

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int VL_W   = $clog2(XLEN + 1),
  localparam int ELEM_W = (XLEN > 1) ? $clog2(XLEN) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobeT                 strobe,
  input  logic [REG_W-1:0]          cmdRd,
  input  logic [REG_W-1:0]          cmdRs1,
  input  logic [REG_W-1:0]          cmdRs2,
  input  logic                      cmdVecRd,
  input  logic                      cmdVecRs1,
  input  logic                      cmdVecRs2,
  input  logic [VL_W-1:0]           cmdVl,
  input  logic [XLEN-1:0]           cmdMask,
  input  logic                      cmdZero,
  output seqStatusT                 status,
  output logic [LANES-1:0]          laneValid,
  output logic [LANES-1:0]          laneEnable,
  output logic [LANES-1:0]          laneZero,
  output logic [LANES*ELEM_W-1:0]   laneElem,
  output logic [LANES*REG_W-1:0]    laneRd,
  output logic [LANES*REG_W-1:0]    laneRs1,
  output logic [LANES*REG_W-1:0]    laneRs2
);

  function automatic logic [ELEM_W-1:0] oneHotToIdx(input logic [XLEN-1:0] oh);
    logic [ELEM_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (oh[i]) idx = idx | ELEM_W'(i);
    end
    return idx;
  endfunction

  // ---------------- command decode ----------------
  logic            allScalar;
  logic [VL_W-1:0] effVl;
  logic [XLEN-1:0] vlMask;
  logic [XLEN-1:0] loadPend;

  assign allScalar = !(cmdVecRd || cmdVecRs1 || cmdVecRs2);
  assign effVl     = (cmdVl == '0) ? '0 : (allScalar ? VL_W'(1) : cmdVl);

  generate
    for (genvar i = 0; i < XLEN; i++) begin : g_vlMask
      assign vlMask[i] = (VL_W'(i) < effVl);
    end
  endgenerate

  assign loadPend = cmdZero ? vlMask : (vlMask & cmdMask);

  // ---------------- held command state ----------------
  logic [XLEN-1:0]  pendQ;
  logic [XLEN-1:0]  maskQ;
  logic             zeroQ;
  logic [REG_W-1:0] rdQ, rs1Q, rs2Q;
  logic             vecRdQ, vecRs1Q, vecRs2Q;
  logic [XLEN-1:0]  pickAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      maskQ   <= '0;
      zeroQ   <= 1'b0;
      rdQ     <= '0;
      rs1Q    <= '0;
      rs2Q    <= '0;
      vecRdQ  <= 1'b0;
      vecRs1Q <= 1'b0;
      vecRs2Q <= 1'b0;
    end else if (strobe.load) begin
      pendQ   <= loadPend;
      maskQ   <= cmdMask;
      zeroQ   <= cmdZero;
      rdQ     <= cmdRd;
      rs1Q    <= cmdRs1;
      rs2Q    <= cmdRs2;
      vecRdQ  <= cmdVecRd;
      vecRs1Q <= cmdVecRs1;
      vecRs2Q <= cmdVecRs2;
    end else if (strobe.advance) begin
      pendQ <= pendQ & ~pickAll;
    end
  end

  // ---------------- lane picking chain ----------------
  logic [XLEN-1:0] remain [LANES+1];
  logic [XLEN-1:0] pick   [LANES];
  logic [XLEN-1:0] pickAcc[LANES+1];

  assign remain[0]  = pendQ;
  assign pickAcc[0] = '0;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ELEM_W-1:0] elemIdx;
      logic [REG_W-1:0]  elemReg;

      assign pick[k]       = remain[k] & (~remain[k] + XLEN'(1));
      assign remain[k+1]   = remain[k] & ~pick[k];
      assign pickAcc[k+1]  = pickAcc[k] | pick[k];
      assign elemIdx       = oneHotToIdx(pick[k]);
      assign elemReg       = REG_W'(elemIdx);

      assign laneValid[k]  = |remain[k];
      assign laneEnable[k] = |(pick[k] & maskQ);
      assign laneZero[k]   = laneValid[k] && !laneEnable[k];

      assign laneElem[k*ELEM_W +: ELEM_W] = elemIdx;
      assign laneRd [k*REG_W +: REG_W] = vecRdQ  ? (rdQ  + elemReg) : rdQ;
      assign laneRs1[k*REG_W +: REG_W] = vecRs1Q ? (rs1Q + elemReg) : rs1Q;
      assign laneRs2[k*REG_W +: REG_W] = vecRs2Q ? (rs2Q + elemReg) : rs2Q;

      if (k > 0) begin : g_order
        // R4: element numbers rise with the lane number
        p_order_r4: assert property (@(posedge clk) disable iff (!rstN)
          laneValid[k] |-> (laneElem[k*ELEM_W +: ELEM_W] > laneElem[(k-1)*ELEM_W +: ELEM_W]));
      end
    end
  endgenerate

  assign pickAll          = pickAcc[LANES];
  assign status.loadEmpty = (loadPend == '0);
  assign status.lastGroup = (remain[LANES] == '0);

  // R3: without zeroing every issued lane is a predicated-on element
  p_zero_off_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!zeroQ && (|laneValid)) |-> ((laneEnable & laneValid) == laneValid));

  // R10: each accepted group retires exactly its filled lanes
  p_progress_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($countones(pendQ) == $past($countones(pendQ)) - $past($countones(laneValid))));

endmodule

// File: rtl/elemIssueSeq.sv
module elemIssueSeq
  import seqPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int VL_W   = $clog2(XLEN + 1),
  localparam int ELEM_W = (XLEN > 1) ? $clog2(XLEN) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [REG_W-1:0]        cmdRd,
  input  logic [REG_W-1:0]        cmdRs1,
  input  logic [REG_W-1:0]        cmdRs2,
  input  logic                    cmdVecRd,
  input  logic                    cmdVecRs1,
  input  logic                    cmdVecRs2,
  input  logic [VL_W-1:0]         cmdVl,
  input  logic [XLEN-1:0]         cmdMask,
  input  logic                    cmdZero,
  output logic                    busy,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES-1:0]        laneValid,
  output logic [LANES-1:0]        laneEnable,
  output logic [LANES-1:0]        laneZero,
  output logic [LANES*ELEM_W-1:0] laneElem,
  output logic [LANES*REG_W-1:0]  laneRd,
  output logic [LANES*REG_W-1:0]  laneRs1,
  output logic [LANES*REG_W-1:0]  laneRs2,
  output logic                    done
);

  seqStrobeT strobe;
  seqStatusT status;

  seqCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe),
    .busy     (busy),
    .outValid (outValid),
    .done     (done)
  );

  seqDatapath #(
    .XLEN  (XLEN),
    .LANES (LANES),
    .REG_W (REG_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdRd      (cmdRd),
    .cmdRs1     (cmdRs1),
    .cmdRs2     (cmdRs2),
    .cmdVecRd   (cmdVecRd),
    .cmdVecRs1  (cmdVecRs1),
    .cmdVecRs2  (cmdVecRs2),
    .cmdVl      (cmdVl),
    .cmdMask    (cmdMask),
    .cmdZero    (cmdZero),
    .status     (status),
    .laneValid  (laneValid),
    .laneEnable (laneEnable),
    .laneZero   (laneZero),
    .laneElem   (laneElem),
    .laneRd     (laneRd),
    .laneRs1    (laneRs1),
    .laneRs2    (laneRs2)
  );

  // R8: a stalled group is held unchanged
  p_hold_group_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(laneValid) && $stable(laneElem)
                                 && $stable(laneRd) && $stable(laneZero)));

  // R4: filled lanes start at lane 0 and are contiguous
  p_packed_lanes_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (laneValid[0] && ((laneValid & (laneValid + LANES'(1))) == '0)));

endmodule

// File: tb/test_elemIssueSeq.sv
module test_elemIssueSeq;

  localparam int XLEN   = 32;
  localparam int LANES  = 4;
  localparam int REG_W  = 5;
  localparam int VL_W   = $clog2(XLEN + 1);
  localparam int ELEM_W = $clog2(XLEN);
  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    start;
  logic [REG_W-1:0]        cmdRd, cmdRs1, cmdRs2;
  logic                    cmdVecRd, cmdVecRs1, cmdVecRs2;
  logic [VL_W-1:0]         cmdVl;
  logic [XLEN-1:0]         cmdMask;
  logic                    cmdZero;
  logic                    busy, outValid, outReady, done;
  logic [LANES-1:0]        laneValid, laneEnable, laneZero;
  logic [LANES*ELEM_W-1:0] laneElem;
  logic [LANES*REG_W-1:0]  laneRd, laneRs1, laneRs2;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elemIssueSeq #(.XLEN(XLEN), .LANES(LANES), .REG_W(REG_W)) i_elemIssueSeq (
    .clk(clk), .rstN(rstN), .start(start),
    .cmdRd(cmdRd), .cmdRs1(cmdRs1), .cmdRs2(cmdRs2),
    .cmdVecRd(cmdVecRd), .cmdVecRs1(cmdVecRs1), .cmdVecRs2(cmdVecRs2),
    .cmdVl(cmdVl), .cmdMask(cmdMask), .cmdZero(cmdZero),
    .busy(busy), .outValid(outValid), .outReady(outReady),
    .laneValid(laneValid), .laneEnable(laneEnable), .laneZero(laneZero),
    .laneElem(laneElem), .laneRd(laneRd), .laneRs1(laneRs1), .laneRs2(laneRs2),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int regAt(input int base, input bit isVec, input int e);
    return isVec ? ((base + e) % (1 << REG_W)) : base;
  endfunction

  task automatic runCmd(input int rd, input int rs1, input int rs2,
                        input bit vRd, input bit vRs1, input bit vRs2,
                        input int vl, input logic [XLEN-1:0] mask,
                        input bit zero, input bit junkStart, input string tag);
    int expElem[XLEN];
    int expN = 0;
    int effVl;
    int idx = 0;
    int groups = 0;
    int cyc = 0;
    bit prevStall = 1'b0;
    logic [LANES-1:0]        pV;
    logic [LANES*ELEM_W-1:0] pE;
    logic [LANES*REG_W-1:0]  pR;
    // expected element list
    if (vl == 0) effVl = 0;
    else if (!(vRd || vRs1 || vRs2)) effVl = 1;
    else effVl = (vl > XLEN) ? XLEN : vl;
    for (int e = 0; e < effVl; e++) begin
      if (zero || mask[e]) begin
        expElem[expN] = e;
        expN++;
      end
    end

    @(negedge clk);
    check(!busy, tag, "R1 idle before start", busy, 0);
    start = 1'b1; cmdRd = REG_W'(rd); cmdRs1 = REG_W'(rs1); cmdRs2 = REG_W'(rs2);
    cmdVecRd = vRd; cmdVecRs1 = vRs1; cmdVecRs2 = vRs2;
    cmdVl = VL_W'(vl); cmdMask = mask; cmdZero = zero; outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;

    if (expN == 0) begin
      check(done == 1'b1, tag, "R9 done after empty command", done, 1);
      check(outValid == 1'b0, tag, "R2 no issue for empty command", outValid, 0);
      return;
    end

    while (idx < expN && cyc < 4000) begin
      check(outValid && !done, tag, "R9 valid and no done mid-run", {outValid, done}, 2);
      if (prevStall)
        check(pV == laneValid && pE == laneElem && pR == laneRd, tag,
              "R8 group held while stalled", laneElem, pE);
      if (junkStart && cyc < 2) begin
        // R1: start while busy must be ignored
        start = 1'b1; cmdVl = VL_W'(XLEN); cmdMask = '1; cmdRd = ~cmdRd;
        cmdVecRd = 1'b1; cmdZero = 1'b1;
      end else begin
        start = 1'b0;
      end
      outReady = (($urandom % 4) != 0);
      if (outReady) begin
        for (int k = 0; k < LANES; k++) begin
          bit ev = (idx + k) < expN;
          check(laneValid[k] == ev, tag, "R4 lane valid", laneValid[k], ev);
          if (ev) begin
            int e = expElem[idx + k];
            bit en = mask[e];
            check(int'(laneElem[k*ELEM_W +: ELEM_W]) == e, tag, "R4 R1 element order",
                  laneElem[k*ELEM_W +: ELEM_W], e);
            check(laneEnable[k] == en && laneZero[k] == !en, tag,
                  zero ? "R6 enable/zero flags" : "R3 enable/zero flags",
                  {laneEnable[k], laneZero[k]}, {en, !en});
            check(int'(laneRd[k*REG_W +: REG_W]) == regAt(rd, vRd, e) &&
                  int'(laneRs1[k*REG_W +: REG_W]) == regAt(rs1, vRs1, e) &&
                  int'(laneRs2[k*REG_W +: REG_W]) == regAt(rs2, vRs2, e), tag,
                  "R5 element registers", laneRs1[k*REG_W +: REG_W], regAt(rs1, vRs1, e));
          end
        end
        idx += LANES;
        groups++;
        prevStall = 1'b0;
      end else begin
        prevStall = 1'b1;
        pV = laneValid; pE = laneElem; pR = laneRd;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    outReady = 1'b0;
    check(done == 1'b1 && busy == 1'b0, tag, "R9 done pulse after last group", {done, busy}, 2);
    check(groups == (expN + LANES - 1) / LANES, tag, "R10 group count", groups,
          (expN + LANES - 1) / LANES);
    @(negedge clk);
    check(done == 1'b0, tag, "R9 done lasts one cycle", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; start = 1'b0; outReady = 1'b0;
    cmdRd = '0; cmdRs1 = '0; cmdRs2 = '0;
    cmdVecRd = 1'b0; cmdVecRs1 = 1'b0; cmdVecRs2 = 1'b0;
    cmdVl = '0; cmdMask = '0; cmdZero = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !outValid && !done, "reset", "R9 idle outputs in reset",
          {busy, outValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !outValid && !done, "reset", "R1 idle after reset",
          {busy, outValid, done}, 0);

    // directed corners
    runCmd(4, 10, 20, 1, 1, 1, 8, 32'h0000_00DB, 0, 0, "six-of-eight R10");
    runCmd(4, 10, 20, 1, 1, 0, 0, '1, 1, 0, "vl-zero R2");
    runCmd(1, 2, 3, 1, 0, 1, 12, '0, 0, 0, "empty-mask R3");
    runCmd(1, 2, 3, 1, 0, 1, 5, '0, 1, 0, "zero-all R6");
    runCmd(30, 28, 0, 1, 1, 0, XLEN, '1, 0, 1, "full-wrap R5 R1");
    runCmd(7, 8, 9, 1, 1, 1, 63, 32'hF0F0_00FF, 1, 0, "vl-over R2 R6");
    runCmd(5, 6, 7, 0, 0, 0, 9, 32'h0000_0002, 0, 0, "scalar-off R7");
    runCmd(5, 6, 7, 0, 0, 0, 9, 32'h0000_0003, 0, 0, "scalar-on R7");
    runCmd(5, 6, 7, 0, 0, 0, 9, 32'h0000_0002, 1, 0, "scalar-zero R7 R6");

    // constrained random commands
    for (int n = 0; n < 200; n++) begin
      int vl = (($urandom % 8) == 0) ? 0 : int'($urandom % (1 << VL_W));
      logic [XLEN-1:0] m = $urandom;
      if (($urandom % 4) == 0) m = m & $urandom;
      runCmd(int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
             1'($urandom), 1'($urandom), 1'($urandom), vl, m,
             1'($urandom), (($urandom % 3) == 0), "random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule